// File: doc/BRIEF.md
# Smart Card Host Control Front End

This block is the digital control layer that sits between a host microcontroller and a smart card interface. The host drives a set of control inputs: power request, reset request, power-down request, voltage choice, a two-bit clock divide code and a clock-mode choice. The block captures them while the host select input is high and holds them while it is low. While the select is low, the three host data lines are also cut off from the card in both directions and the interrupt pull is released.

The card clock is derived from a reference clock. The block's `clk` runs at twice the reference rate, and the reference itself is produced on `refclk_buf` by toggling it on every `clk` edge. In sequencer mode a small activation sequencer drives the card clock and card reset through a power handshake: it requests supply, waits for the supply-good input, runs the clock for a fixed number of rising edges with reset held, and then lets reset follow the host. In direct mode the card clock is the host strobe and card reset is the held host reset input.

An interrupt flag is raised on card insertion or removal and on a fault pulse. The host clears it with a status-read strobe. The flag drives an active-low open-drain output, modelled as a pull-enable.

Top module: `sc_host_front`

## Requirements
- R1: The divide code `div_sel` sets the card clock period in `clk` cycles: 2'b00 gives 16 (reference/8), 2'b01 gives 8 (reference/4), 2'b11 gives 4 (reference/2), and 2'b10 gives 2 (the undivided reference rate).
- R2: A new divide code takes effect only at a falling edge of the card clock. A high phase that is already under way completes at the old length.
- R3: When `host_sel` is high at a clock edge, the control inputs are captured at that edge. While it is low, the captured values are held, so a changed `volt_hi` has no effect on `volt_5v`.
- R4: While `host_sel` is low, `host_dat_o` and `card_dat_o` are all ones and `irq_pull` is 0. While it is high, each line passes the opposite side's input.
- R5: In sequencer mode, a held low `pwr_req_n` raises `vcc_en`. The card clock stays low until `vcc_good` is seen. Card reset then stays high through the first WAIT_EDGES (4) card clock rising edges, and it first follows the held `host_rst` on the next rising edge.
- R6: While active in sequencer mode, `card_rst` changes only together with a rising edge of `card_clk`.
- R7: A held high `pwr_req_n`, or loss of `vcc_good`, drops `vcc_en`, raises `card_rst` and stops the card clock low. After a supply loss, power is not requested again until `pwr_req_n` has gone high.
- R8: With the held `direct_mode` at 1, `card_clk` equals `host_strobe` in the same cycle and `card_rst` equals the held `host_rst`.
- R9: `pd_mode` is the held `pd_req` while the held `pwr_req_n` is 1, and 0 while a session is requested.
- R10: `volt_5v` follows the held `volt_hi` (1 = 5 V, 0 = 3 V) and is 1 after reset.
- R11: A change of `card_in` or a high `fault` sets the interrupt flag. A `stat_rd` pulse while `host_sel` is high clears it, and a set in the same cycle wins. `irq_pull` is the flag gated by `host_sel`. After reset the flag is clear, and `vcc_en` is 0, `card_rst` is 1 and `card_clk` is 0.
- R12: `refclk_buf` toggles on every `clk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the reference rate |
| rst | input | 1 | Synchronous reset, active high |
| host_sel | input | 1 | Host select: 1 = capture controls and pass data |
| pwr_req_n | input | 1 | Card power request, active low |
| host_rst | input | 1 | Host reset request for the card |
| pd_req | input | 1 | Power-down request, active high |
| volt_hi | input | 1 | Voltage choice: 1 = 5 V, 0 = 3 V |
| div_sel | input | 2 | Card clock divide code |
| direct_mode | input | 1 | 1 = card clock and reset under direct host control |
| host_strobe | input | 1 | Host clock source used in direct mode |
| vcc_good | input | 1 | Card supply is in range |
| card_in | input | 1 | Card presence |
| fault | input | 1 | Fault event pulse |
| stat_rd | input | 1 | Host status read strobe, clears the interrupt flag |
| host_dat_i | input | 3 | Data driven by the host toward the card |
| card_dat_i | input | 3 | Data driven by the card toward the host |
| refclk_buf | output | 1 | Buffered reference clock |
| card_clk | output | 1 | Card clock |
| card_rst | output | 1 | Card reset, 1 = asserted |
| vcc_en | output | 1 | Card supply enable |
| volt_5v | output | 1 | Selected card voltage, 1 = 5 V |
| pd_mode | output | 1 | Power-down in effect |
| irq_pull | output | 1 | Interrupt pull-low enable (open drain) |
| host_dat_o | output | 3 | Data toward the host, all ones when isolated |
| card_dat_o | output | 3 | Data toward the card, all ones when isolated |

## Verification
The hardest situation to reach from the ports is a divide-code change that lands inside a high phase of the card clock. To reach it, the bench first completes a full activation. It then watches the card clock at each falling `clk` edge and drives the new code on the very sample where the first high level appears. The next hardest is the cycle in which card reset releases. The bench counts card clock rising edges from the moment supply is reported good, and checks that the release coincides with the fifth edge.

// File: rtl/sc_front_pkg.sv
package sc_front_pkg;

    localparam int HALF_W = 4;

    typedef enum logic [1:0] {
        SEQ_OFF,
        SEQ_PWR,
        SEQ_CLK,
        SEQ_ON
    } seq_state_t;

    typedef struct packed {
        logic       pwr_req_n;
        logic       host_rst;
        logic       pd_req;
        logic       volt_hi;
        logic [1:0] div_sel;
        logic       direct_mode;
    } host_ctrl_t;

    localparam host_ctrl_t CTRL_RESET = '{
        pwr_req_n:   1'b1,
        host_rst:    1'b0,
        pd_req:      1'b0,
        volt_hi:     1'b1,
        div_sel:     2'b00,
        direct_mode: 1'b0
    };

    // Half period of the card clock, in clk cycles, for each divide code.
    function automatic logic [HALF_W-1:0] half_period(input logic [1:0] code);
        case (code)
            2'b00:   return HALF_W'(8);
            2'b01:   return HALF_W'(4);
            2'b11:   return HALF_W'(2);
            default: return HALF_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/sc_ctrl_latch.sv
module sc_ctrl_latch
    import sc_front_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel,
    input  host_ctrl_t d,
    output host_ctrl_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= CTRL_RESET;
        end else if (sel) begin
            q <= d;
        end
    end

    // R3: captured controls hold while the select is low
    assert_hold_when_deselected_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(sel) && !$past(rst)) |-> $stable(q))
        else $error("controls changed while deselected");

endmodule

// File: rtl/sc_clk_div.sv
module sc_clk_div
    import sc_front_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] code,
    output logic       dclk,
    output logic       rise
);

    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] half_q;
    logic              tick;

    assign tick = (cnt_q == HALF_W'(1));
    assign rise = tick && !dclk && run;

    always_ff @(posedge clk) begin
        if (rst) begin
            dclk   <= 1'b0;
            half_q <= half_period(2'b00);
            cnt_q  <= half_period(2'b00);
        end else if (tick) begin
            if (dclk) begin
                // falling edge: the only point where a new ratio is adopted
                dclk   <= 1'b0;
                half_q <= half_period(code);
                cnt_q  <= half_period(code);
            end else begin
                dclk  <= run;
                cnt_q <= half_q;
            end
        end else begin
            cnt_q <= cnt_q - HALF_W'(1);
        end
    end

    // R2: the active half period changes only at a falling card clock edge
    assert_ratio_at_fall_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(half_q) |-> $fell(dclk))
        else $error("divide ratio changed away from a falling edge");

endmodule

// File: rtl/sc_seq.sv
module sc_seq
    import sc_front_pkg::*;
#(
    parameter int WAIT_EDGES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic req_n,
    input  logic vcc_ok,
    input  logic rise,
    input  logic rst_req,
    output logic vcc_en,
    output logic clk_run,
    output logic card_rst
);

    localparam int WCW = $clog2(WAIT_EDGES) + 1;

    seq_state_t       state_q, state_n;
    logic [WCW-1:0]   wcnt_q;
    logic             lock_q;

    always_comb begin
        state_n = state_q;
        case (state_q)
            SEQ_OFF: if (!req_n && !lock_q) state_n = SEQ_PWR;
            SEQ_PWR: begin
                if (req_n)       state_n = SEQ_OFF;
                else if (vcc_ok) state_n = SEQ_CLK;
            end
            SEQ_CLK: begin
                if (req_n || !vcc_ok) state_n = SEQ_OFF;
                else if (rise && wcnt_q == WCW'(WAIT_EDGES - 1)) state_n = SEQ_ON;
            end
            SEQ_ON:  if (req_n || !vcc_ok) state_n = SEQ_OFF;
            default: state_n = SEQ_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_OFF;
            wcnt_q  <= '0;
            lock_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            if (state_q != SEQ_CLK) wcnt_q <= '0;
            else if (rise)          wcnt_q <= wcnt_q + WCW'(1);
            if (req_n)
                lock_q <= 1'b0;
            else if ((state_q == SEQ_CLK || state_q == SEQ_ON) && !vcc_ok)
                lock_q <= 1'b1;
        end
    end

    // Reset releases only on a rising card clock edge inside the active state.
    always_ff @(posedge clk) begin
        if (rst)
            card_rst <= 1'b1;
        else if (state_q != SEQ_ON || state_n != SEQ_ON)
            card_rst <= 1'b1;
        else if (rise)
            card_rst <= rst_req;
    end

    assign vcc_en  = (state_q != SEQ_OFF);
    assign clk_run = (state_q == SEQ_CLK) || (state_q == SEQ_ON);

    // R7: with the supply off the card is always held in reset
    assert_rst_when_unpowered_R7: assert property (@(posedge clk) disable iff (rst)
        !vcc_en |-> card_rst)
        else $error("card reset released without supply");

    // R5: no card clock before supply is requested
    assert_no_clock_unpowered_R5: assert property (@(posedge clk) disable iff (rst)
        !vcc_en |-> !clk_run)
        else $error("card clock enabled without supply");

endmodule

// File: rtl/sc_irq.sv
module sc_irq (
    input  logic clk,
    input  logic rst,
    input  logic present,
    input  logic fault,
    input  logic rd,
    input  logic sel,
    output logic pull
);

    logic prev_q;
    logic flag_q;
    logic event_w;

    assign event_w = (present != prev_q) || fault;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= present;
            flag_q <= 1'b0;
        end else begin
            prev_q <= present;
            if (event_w)
                flag_q <= 1'b1;
            else if (rd && sel)
                flag_q <= 1'b0;
        end
    end

    assign pull = flag_q && sel;

    // R11: a presence change always leaves the flag set
    assert_presence_sets_flag_R11: assert property (@(posedge clk) disable iff (rst)
        (present != $past(present)) |=> flag_q)
        else $error("presence change did not raise the flag");

endmodule

// File: rtl/sc_host_front.sv
module sc_host_front
    import sc_front_pkg::*;
#(
    parameter int N_DATA     = 3,
    parameter int WAIT_EDGES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_sel,
    input  logic              pwr_req_n,
    input  logic              host_rst,
    input  logic              pd_req,
    input  logic              volt_hi,
    input  logic [1:0]        div_sel,
    input  logic              direct_mode,
    input  logic              host_strobe,
    input  logic              vcc_good,
    input  logic              card_in,
    input  logic              fault,
    input  logic              stat_rd,
    input  logic [N_DATA-1:0] host_dat_i,
    input  logic [N_DATA-1:0] card_dat_i,
    output logic              refclk_buf,
    output logic              card_clk,
    output logic              card_rst,
    output logic              vcc_en,
    output logic              volt_5v,
    output logic              pd_mode,
    output logic              irq_pull,
    output logic [N_DATA-1:0] host_dat_o,
    output logic [N_DATA-1:0] card_dat_o
);

    host_ctrl_t ctrl_d, ctrl_q;
    logic       div_clk, div_rise, clk_run, seq_rst;
    logic       ref_q;

    assign ctrl_d = '{
        pwr_req_n:   pwr_req_n,
        host_rst:    host_rst,
        pd_req:      pd_req,
        volt_hi:     volt_hi,
        div_sel:     div_sel,
        direct_mode: direct_mode
    };

    sc_ctrl_latch u_latch (
        .clk (clk),
        .rst (rst),
        .sel (host_sel),
        .d   (ctrl_d),
        .q   (ctrl_q)
    );

    sc_clk_div u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (clk_run),
        .code (ctrl_q.div_sel),
        .dclk (div_clk),
        .rise (div_rise)
    );

    sc_seq #(.WAIT_EDGES(WAIT_EDGES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_n    (ctrl_q.pwr_req_n),
        .vcc_ok   (vcc_good),
        .rise     (div_rise),
        .rst_req  (ctrl_q.host_rst),
        .vcc_en   (vcc_en),
        .clk_run  (clk_run),
        .card_rst (seq_rst)
    );

    sc_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .present (card_in),
        .fault   (fault),
        .rd      (stat_rd),
        .sel     (host_sel),
        .pull    (irq_pull)
    );

    // Reference clock: half the block clock rate.
    always_ff @(posedge clk) begin
        if (rst) ref_q <= 1'b0;
        else     ref_q <= ~ref_q;
    end
    assign refclk_buf = ref_q;

    assign card_clk = ctrl_q.direct_mode ? host_strobe      : div_clk;
    assign card_rst = ctrl_q.direct_mode ? ctrl_q.host_rst  : seq_rst;
    assign volt_5v  = ctrl_q.volt_hi;
    assign pd_mode  = ctrl_q.pd_req && ctrl_q.pwr_req_n;

    // Data lines: pass while selected, weak high level while isolated.
    for (genvar i = 0; i < N_DATA; i++) begin : g_line
        assign card_dat_o[i] = host_sel ? host_dat_i[i] : 1'b1;
        assign host_dat_o[i] = host_sel ? card_dat_i[i] : 1'b1;
    end

    // R6: the sequencer releases card reset only with a rising card clock
    assert_rst_release_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(seq_rst) |-> $rose(div_clk))
        else $error("card reset released off a clock edge");

    // R12: the reference copy toggles on every edge
    assert_ref_toggles_R12: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> !$stable(ref_q))
        else $error("reference copy missed a toggle");

endmodule

// File: tb/sc_host_front_test.sv
module sc_host_front_test;

    localparam int WAIT_EDGES = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_sel = 1'b1, pwr_req_n = 1'b1, host_rst = 1'b0, pd_req = 1'b0;
    logic       volt_hi = 1'b1, direct_mode = 1'b0, host_strobe = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic       vcc_good = 1'b0, card_in = 1'b0, fault = 1'b0, stat_rd = 1'b0;
    logic [2:0] host_dat_i = 3'b000, card_dat_i = 3'b000;
    logic       refclk_buf, card_clk, card_rst, vcc_en, volt_5v, pd_mode, irq_pull;
    logic [2:0] host_dat_o, card_dat_o;

    int n_tests = 0;
    int n_fail  = 0;

    sc_host_front uut (
        .clk(clk), .rst(rst), .host_sel(host_sel), .pwr_req_n(pwr_req_n),
        .host_rst(host_rst), .pd_req(pd_req), .volt_hi(volt_hi), .div_sel(div_sel),
        .direct_mode(direct_mode), .host_strobe(host_strobe), .vcc_good(vcc_good),
        .card_in(card_in), .fault(fault), .stat_rd(stat_rd),
        .host_dat_i(host_dat_i), .card_dat_i(card_dat_i),
        .refclk_buf(refclk_buf), .card_clk(card_clk), .card_rst(card_rst),
        .vcc_en(vcc_en), .volt_5v(volt_5v), .pd_mode(pd_mode), .irq_pull(irq_pull),
        .host_dat_o(host_dat_o), .card_dat_o(card_dat_o)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rise(output bit ok);
        bit p;
        ok = 1'b0;
        p  = card_clk;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (!p && card_clk) begin
                ok = 1'b1;
                return;
            end
            p = card_clk;
        end
    endtask

    task automatic measure_period(output int per);
        bit ok, p;
        per = 0;
        wait_rise(ok);
        if (!ok) return;
        p = 1'b1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            per++;
            if (!p && card_clk) return;
            p = card_clk;
        end
        per = -1;
    endtask

    task automatic t_reset;
        cyc(1);
        check(vcc_en == 0,   "R11 reset vcc_en",   vcc_en,   0);
        check(card_rst == 1, "R11 reset card_rst", card_rst, 1);
        check(card_clk == 0, "R11 reset card_clk", card_clk, 0);
        check(irq_pull == 0, "R11 reset irq_pull", irq_pull, 0);
        check(volt_5v == 1,  "R10 reset volt_5v",  volt_5v,  1);
        check(pd_mode == 0,  "R9 reset pd_mode",   pd_mode,  0);
    endtask

    task automatic t_refclk;
        bit p;
        int bad = 0;
        p = refclk_buf;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (refclk_buf == p) bad++;
            p = refclk_buf;
        end
        check(bad == 0, "R12 refclk toggle misses", bad, 0);
    endtask

    task automatic t_latch;
        host_sel = 1'b0; volt_hi = 1'b0;
        cyc(5);
        check(volt_5v == 1, "R3 held while deselected", volt_5v, 1);
        check(volt_5v == 1, "R10 volt_5v unchanged", volt_5v, 1);
        host_sel = 1'b1;
        cyc(2);
        check(volt_5v == 0, "R10 volt_5v 3V after capture", volt_5v, 0);
        volt_hi = 1'b1;
        cyc(2);
        check(volt_5v == 1, "R3 recapture 5V", volt_5v, 1);
    endtask

    task automatic t_isolate;
        host_dat_i = 3'b010; card_dat_i = 3'b101;
        cyc(1);
        check(card_dat_o == 3'b010, "R4 host to card", card_dat_o, 3'b010);
        check(host_dat_o == 3'b101, "R4 card to host", host_dat_o, 3'b101);
        host_sel = 1'b0;
        cyc(1);
        check(card_dat_o == 3'b111, "R4 card side isolated", card_dat_o, 3'b111);
        check(host_dat_o == 3'b111, "R4 host side isolated", host_dat_o, 3'b111);
        host_sel = 1'b1;
        cyc(1);
    endtask

    task automatic t_activate;
        int ones = 0, rises = 0;
        bit p, aligned = 1'b0, seen = 1'b0;
        pwr_req_n = 1'b0; host_rst = 1'b0;
        cyc(4);
        check(vcc_en == 1, "R5 vcc_en after request", vcc_en, 1);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (card_clk) ones++;
        end
        check(ones == 0, "R5 no clock before supply good", ones, 0);
        check(card_rst == 1, "R5 reset held before supply good", card_rst, 1);
        vcc_good = 1'b1;
        p = card_clk;
        for (int k = 0; k < 300 && !seen; k++) begin
            @(negedge clk);
            if (!p && card_clk) rises++;
            if (!card_rst) begin
                seen = 1'b1;
                aligned = !p && card_clk;
            end
            p = card_clk;
        end
        check(seen && rises == WAIT_EDGES + 1, "R5 rising edges before release", rises, WAIT_EDGES + 1);
        check(aligned, "R6 release on rising edge", aligned, 1);
    endtask

    task automatic t_divide;
        logic [1:0] codes [4] = '{2'b00, 2'b01, 2'b11, 2'b10};
        int         exp   [4] = '{16, 8, 4, 2};
        int per;
        for (int i = 0; i < 4; i++) begin
            div_sel = codes[i];
            cyc(40);
            measure_period(per);
            check(per == exp[i], "R1 card clock period", per, exp[i]);
        end
    endtask

    task automatic t_boundary;
        bit ok;
        int hi;
        div_sel = 2'b00;
        cyc(40);
        wait_rise(ok);
        hi = 1;
        div_sel = 2'b10;
        for (int k = 0; k < 40 && card_clk; k++) begin
            @(negedge clk);
            if (card_clk) hi++;
        end
        check(hi == 8, "R2 high phase keeps old length", hi, 8);
        wait_rise(ok);
        hi = 1;
        @(negedge clk);
        if (card_clk) hi++;
        check(ok && hi == 1, "R2 new ratio after fall", hi, 1);
    endtask

    task automatic t_rst_follow;
        bit p, seen, aligned;
        for (int v = 1; v >= 0; v--) begin
            host_rst = v[0];
            seen = 1'b0; aligned = 1'b0;
            p = card_clk;
            for (int k = 0; k < 60 && !seen; k++) begin
                @(negedge clk);
                if (card_rst == v[0]) begin
                    seen = 1'b1;
                    aligned = !p && card_clk;
                end
                p = card_clk;
            end
            check(seen, "R6 card_rst follows host_rst", card_rst, v);
            check(aligned, "R6 change on rising edge", aligned, 1);
        end
    endtask

    task automatic t_direct;
        direct_mode = 1'b1;
        cyc(2);
        host_strobe = 1'b1; #1;
        check(card_clk == 1, "R8 strobe high", card_clk, 1);
        @(negedge clk);
        host_strobe = 1'b0; #1;
        check(card_clk == 0, "R8 strobe low", card_clk, 0);
        host_rst = 1'b1;
        cyc(2);
        check(card_rst == 1, "R8 reset direct high", card_rst, 1);
        host_rst = 1'b0;
        cyc(2);
        check(card_rst == 0, "R8 reset direct low", card_rst, 0);
        direct_mode = 1'b0;
        cyc(2);
    endtask

    task automatic t_deact_pd;
        int ones = 0;
        pd_req = 1'b1;
        cyc(3);
        check(pd_mode == 0, "R9 power-down ignored in session", pd_mode, 0);
        pwr_req_n = 1'b1;
        cyc(3);
        check(vcc_en == 0,   "R7 supply dropped", vcc_en, 0);
        check(card_rst == 1, "R7 reset asserted", card_rst, 1);
        check(pd_mode == 1,  "R9 power-down out of session", pd_mode, 1);
        cyc(20);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (card_clk) ones++;
        end
        check(ones == 0, "R7 clock stopped low", ones, 0);
        pd_req = 1'b0;
        cyc(2);
        check(pd_mode == 0, "R9 power-down released", pd_mode, 0);
    endtask

    task automatic t_vcc_drop;
        pwr_req_n = 1'b0;
        cyc(150);
        check(card_rst == 0, "R5 reactivated reset follows host", card_rst, 0);
        vcc_good = 1'b0;
        cyc(3);
        check(vcc_en == 0,   "R7 supply loss drops vcc_en", vcc_en, 0);
        check(card_rst == 1, "R7 supply loss asserts reset", card_rst, 1);
        cyc(10);
        check(vcc_en == 0, "R7 no retry until request withdrawn", vcc_en, 0);
        pwr_req_n = 1'b1;
        vcc_good = 1'b1;
        cyc(3);
    endtask

    task automatic t_irq;
        card_in = 1'b1;
        cyc(2);
        check(irq_pull == 1, "R11 insertion sets flag", irq_pull, 1);
        stat_rd = 1'b1; cyc(1); stat_rd = 1'b0; cyc(1);
        check(irq_pull == 0, "R11 read clears flag", irq_pull, 0);
        fault = 1'b1; stat_rd = 1'b1; cyc(1); fault = 1'b0; stat_rd = 1'b0; cyc(1);
        check(irq_pull == 1, "R11 event wins over read", irq_pull, 1);
        host_sel = 1'b0; cyc(1);
        check(irq_pull == 0, "R4 interrupt released while deselected", irq_pull, 0);
        stat_rd = 1'b1; cyc(1); stat_rd = 1'b0; host_sel = 1'b1; cyc(1);
        check(irq_pull == 1, "R11 read ignored while deselected", irq_pull, 1);
        stat_rd = 1'b1; cyc(1); stat_rd = 1'b0; cyc(1);
        card_in = 1'b0;
        cyc(2);
        check(irq_pull == 1, "R11 removal sets flag", irq_pull, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_refclk();
        t_latch();
        t_isolate();
        t_activate();
        t_divide();
        t_boundary();
        t_rst_follow();
        t_direct();
        t_deact_pd();
        t_vcc_drop();
        t_irq();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule